// File: doc/BRIEF.md
# Sequential Byte-Product 16x16 Multiplier

This block forms the 32-bit unsigned product of two 16-bit operands with a single 8x8 multiplier. It is used four times, once per byte pair. Both operands are handled as little-endian bytes. An outer loop walks the bytes of the second operand (B). An inner loop walks the bytes of the first operand (A). Each 16-bit byte product is folded into a four-byte little-endian result buffer at byte offset i+j, where i indexes A and j indexes B.

Every step is a fixed read-modify-write sequence over the buffer:

1. Register the byte product.
2. Add its low byte into byte k.
3. Add its high byte and the carry into byte k+1.
4. Add the remaining carry into byte k+2.

The offset k moves up by one after each inner step and back down by one after each completed inner loop, so every step lands at i+j. A start strobe in the idle state captures the operands and clears the buffer. A one-cycle done flag marks the finished product, and the result stays on its output until the next accepted start.

Top module: `bmul16_seq`

## Requirements
- R1: A start_i pulse sampled while idle captures op_a_i and op_b_i and clears result_o to 0x00000000 in the next cycle.
- R2: Steps run in the order (A byte 0, B byte 0), (A byte 1, B byte 0), (A byte 0, B byte 1), (A byte 1, B byte 1), with byte 0 being bits 7:0. Each step adds A byte i times B byte j at byte offset i+j. Right after the last edge of step s, result_o equals the sum of the first s+1 of these shifted products.
- R3: Each step takes exactly four cycles: product, low-byte add at k, high-byte-plus-carry add at k+1, carry add at k+2. Once the last step completes, byte offset k+2 would be byte 4; any carry there is discarded.
- R4: done_o is high for exactly one cycle, in the cycle after the 16th rising edge following the accepting edge. In that cycle result_o equals A*B.
- R5: start_i and operand changes while busy have no effect on the running product.
- R6: While idle and without start, result_o holds its value.
- R7: While rst_n is low, result_o is 0 and done_o is 0. rst_n asserts asynchronously and its release takes effect two clock edges later.
- R8: A = 0x000C and B = 0x020F (little-endian bytes 0C 00 0F 02) give 0x000018B4.
- R9: All-ones operands give 0xFFFE0001, so every carry path is exercised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| op_a_i | input | 16 | Operand A, unsigned |
| op_b_i | input | 16 | Operand B, unsigned |
| result_o | output | 32 | Result buffer, little-endian bytes |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The cleared buffer is due one cycle after the accepting edge. Each partial sum is due right after edges 4, 8, 12 and 16, and done_o is due right after edge 16. The bench model counts edges since acceptance and compares result_o only at those step boundaries and while idle, skipping the mid-step cycles where only some bytes have been written. done_o is compared on every falling edge. Explicit product checks at the 16th edge cover the named operand pairs.

// File: rtl/bmul_pkg.sv
package bmul_pkg;

  // Sequencer phases: one product cycle and three buffer update cycles per step.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_MUL  = 3'd1,
    PH_LO   = 3'd2,
    PH_HI   = 3'd3,
    PH_CY   = 3'd4
  } phase_e;

endpackage

// File: rtl/bmul_ctrl.sv
module bmul_ctrl
  import bmul_pkg::*;
#(
  parameter int N_BYTES = 2,
  parameter int IDX_W   = 1,
  parameter int K_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_a_o,
  output logic [IDX_W-1:0] idx_b_o,
  output logic [K_W-1:0]   off_k_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] ia_q, ia_d;
  logic [IDX_W-1:0] ib_q, ib_d;
  logic [K_W-1:0]   k_q, k_d;
  logic             done_q, done_d;
  logic             last_a, last_b;
  logic             accept;
  logic             idx_en;

  assign last_a = (ia_q == LAST_IDX);
  assign last_b = (ib_q == LAST_IDX);

  // Next-state logic
  always_comb begin
    ph_d   = ph_q;
    ia_d   = ia_q;
    ib_d   = ib_q;
    k_d    = k_q;
    done_d = 1'b0;
    accept = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d   = PH_MUL;
          ia_d   = '0;
          ib_d   = '0;
          k_d    = '0;
          accept = 1'b1;
        end
      end
      PH_MUL: ph_d = PH_LO;
      PH_LO:  ph_d = PH_HI;
      PH_HI:  ph_d = PH_CY;
      PH_CY: begin
        // offset rises after every inner step, falls back once per inner loop
        k_d = k_q + K_W'(1) - (last_a ? K_W'(1) : K_W'(0));
        if (last_a) begin
          ia_d = '0;
          if (last_b) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end else begin
            ib_d = ib_q + IDX_W'(1);
            ph_d = PH_MUL;
          end
        end else begin
          ia_d = ia_q + IDX_W'(1);
          ph_d = PH_MUL;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign idx_en = accept || (ph_q == PH_CY);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia_q <= '0;
      ib_q <= '0;
      k_q  <= '0;
    end else if (idx_en) begin
      ia_q <= ia_d;
      ib_q <= ib_d;
      k_q  <= k_d;
    end
  end

  assign phase_o  = ph_q;
  assign idx_a_o  = ia_q;
  assign idx_b_o  = ib_q;
  assign off_k_o  = k_q;
  assign accept_o = accept;
  assign busy_o   = (ph_q != PH_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/bmul_byte_mul.sv
module bmul_byte_mul #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [BYTE_W-1:0]   a_i,
  input  logic [BYTE_W-1:0]   b_i,
  output logic [2*BYTE_W-1:0] prod_o
);

  localparam int PROD_W = 2 * BYTE_W;

  logic [PROD_W-1:0] prod_d, prod_q;

  always_comb begin
    prod_d = PROD_W'(a_i) * PROD_W'(b_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (en_i) begin
      prod_q <= prod_d;
    end
  end

  assign prod_o = prod_q;

endmodule

// File: rtl/bmul_accum.sv
module bmul_accum
  import bmul_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int RES_BYTES = 4,
  parameter int K_W       = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  phase_e                        phase_i,
  input  logic [K_W-1:0]                k_i,
  input  logic [2*BYTE_W-1:0]           prod_i,
  output logic [RES_BYTES*BYTE_W-1:0]   result_o
);

  localparam int TGT_W = K_W + 1;

  logic [BYTE_W-1:0] buf_q [RES_BYTES];
  logic              cy_q, cy_d;
  logic [TGT_W-1:0]  tgt;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] addend;
  logic              cin;
  logic [BYTE_W:0]   sum;
  logic              acc_ph;

  assign acc_ph = (phase_i == PH_LO) || (phase_i == PH_HI) || (phase_i == PH_CY);

  // Target byte, addend and carry-in for the current update cycle
  always_comb begin
    tgt    = TGT_W'(k_i);
    addend = '0;
    cin    = 1'b0;
    case (phase_i)
      PH_LO: begin
        addend = prod_i[BYTE_W-1:0];
      end
      PH_HI: begin
        tgt    = TGT_W'(k_i) + TGT_W'(1);
        addend = prod_i[2*BYTE_W-1:BYTE_W];
        cin    = cy_q;
      end
      PH_CY: begin
        tgt = TGT_W'(k_i) + TGT_W'(2);
        cin = cy_q;
      end
      default: ;
    endcase
  end

  // Read port: a byte beyond the buffer reads as zero
  always_comb begin
    rd_byte = '0;
    for (int n = 0; n < RES_BYTES; n++) begin
      if (tgt == TGT_W'(n)) rd_byte = buf_q[n];
    end
  end

  assign sum = {1'b0, rd_byte} + {1'b0, addend} + {{BYTE_W{1'b0}}, cin};

  always_comb begin
    cy_d = cy_q;
    if (clear_i) begin
      cy_d = 1'b0;
    end else if (phase_i == PH_LO || phase_i == PH_HI) begin
      cy_d = sum[BYTE_W];
    end else if (phase_i == PH_CY) begin
      cy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
    end else begin
      cy_q <= cy_d;
    end
  end

  // One register per result byte, each with its own write enable
  for (genvar g = 0; g < RES_BYTES; g++) begin : g_byte
    logic              we;
    logic [BYTE_W-1:0] nxt;

    assign we  = clear_i || (acc_ph && (tgt == TGT_W'(g)));
    assign nxt = clear_i ? '0 : sum[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[g] <= '0;
      end else if (we) begin
        buf_q[g] <= nxt;
      end
    end

    assign result_o[g*BYTE_W +: BYTE_W] = buf_q[g];
  end

endmodule

// File: rtl/bmul16_seq.sv
module bmul16_seq
  import bmul_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  output logic [2*OP_W-1:0] result_o,
  output logic              done_o
);

  localparam int N_BYTES   = OP_W / BYTE_W;
  localparam int RES_BYTES = 2 * N_BYTES;
  localparam int IDX_W     = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam int K_W       = $clog2(RES_BYTES + 1);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rs_q[1];

  phase_e            phase;
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [K_W-1:0]    off_k;
  logic              accept;
  logic              busy;
  logic [OP_W-1:0]   op_a_q, op_b_q;
  logic [BYTE_W-1:0] a_byte, b_byte;
  logic [2*BYTE_W-1:0] prod;

  bmul_ctrl #(
    .N_BYTES(N_BYTES),
    .IDX_W  (IDX_W),
    .K_W    (K_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .phase_o (phase),
    .idx_a_o (idx_a),
    .idx_b_o (idx_b),
    .off_k_o (off_k),
    .accept_o(accept),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  // Operand capture, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_a_q <= '0;
      op_b_q <= '0;
    end else if (accept) begin
      op_a_q <= op_a_i;
      op_b_q <= op_b_i;
    end
  end

  assign a_byte = op_a_q[idx_a*BYTE_W +: BYTE_W];
  assign b_byte = op_b_q[idx_b*BYTE_W +: BYTE_W];

  bmul_byte_mul #(
    .BYTE_W(BYTE_W)
  ) u_mul (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (phase == PH_MUL),
    .a_i   (a_byte),
    .b_i   (b_byte),
    .prod_o(prod)
  );

  bmul_accum #(
    .BYTE_W   (BYTE_W),
    .RES_BYTES(RES_BYTES),
    .K_W      (K_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (accept),
    .phase_i (phase),
    .k_i     (off_k),
    .prod_i  (prod),
    .result_o(result_o)
  );

endmodule

// File: rtl/bmul_checker.sv
module bmul_checker
  import bmul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy,
  input phase_e            phase,
  input logic [OP_W-1:0]   op_a_q,
  input logic [OP_W-1:0]   op_b_q,
  input logic [2*OP_W-1:0] result_o,
  input logic              done_o
);

  p_clear_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (busy && result_o == '0));

  p_lo_after_mul_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MUL) |=> (phase == PH_LO));

  p_hi_after_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LO) |=> (phase == PH_HI));

  p_cy_after_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HI) |=> (phase == PH_CY));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o == ({{OP_W{1'b0}}, op_a_q} * {{OP_W{1'b0}}, op_b_q})));

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy));

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(op_a_q) && $stable(op_b_q)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(result_o));

endmodule

bind bmul16_seq bmul_checker #(.OP_W(OP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .busy    (busy),
  .phase   (phase),
  .op_a_q  (op_a_q),
  .op_b_q  (op_b_q),
  .result_o(result_o),
  .done_o  (done_o)
);

// File: tb/sim_bmul16_seq.sv
`timescale 1ns/1ps
module sim_bmul16_seq;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] op_a, op_b;
  logic [31:0] result;
  logic        done;

  int compared   = 0;
  int mismatched = 0;
  int cyc        = 0;
  bit finished   = 0;

  bmul16_seq u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .op_a_i  (op_a),
    .op_b_i  (op_b),
    .result_o(result),
    .done_o  (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: counts edges since the accepting edge
  int          m_cnt;
  logic [15:0] m_a, m_b;
  logic [31:0] m_res;
  bit          m_done;
  bit          m_chk;
  string       m_tag;

  function automatic logic [31:0] step_term(input logic [15:0] a, input logic [15:0] b, input int s);
    int i, j;
    logic [31:0] p;
    i = s % 2;
    j = s / 2;
    p = 32'(a[i*8 +: 8]) * 32'(b[j*8 +: 8]);
    return p << (8 * (i + j));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  = -1;
      m_res  = 32'h0;
      m_done = 1'b0;
      m_chk  = 1'b1;
      m_tag  = "R7";
      m_a    = '0;
      m_b    = '0;
    end else begin
      m_done = 1'b0;
      if (m_cnt < 0) begin
        m_chk = 1'b1;
        if (start) begin
          m_a   = op_a;
          m_b   = op_b;
          m_res = 32'h0;
          m_cnt = 0;
          m_tag = "R1";
        end else begin
          m_tag = "R6";
        end
      end else begin
        m_cnt = m_cnt + 1;
        if (m_cnt % 4 == 0) begin
          m_res = m_res + step_term(m_a, m_b, m_cnt / 4 - 1);
          m_chk = 1'b1;
          m_tag = "R2 R3";
        end else begin
          m_chk = 1'b0;
        end
        if (m_cnt == 16) begin
          m_done = 1'b1;
          m_cnt  = -1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done === m_done, "R4 done", {31'b0, done}, {31'b0, m_done});
      if (m_chk) check(result === m_res, m_tag, result, m_res);
    end
  end

  // Start at the current falling edge; return at the falling edge after edge 16
  task automatic run_op(input logic [15:0] a, input logic [15:0] b);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic final_check(input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [31:0] exp;
    exp = 32'(a) * 32'(b);
    check(done === 1'b1, {tag, " R4 done at edge 16"}, {31'b0, done}, 32'h1);
    check(result === exp, {tag, " R4 product"}, result, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(negedge clk);
    check(result === 32'h0, "R7 reset result", result, 32'h0);
    check(done === 1'b0, "R7 reset done", {31'b0, done}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: bytes 0C 00 0F 02
    run_op(16'h000C, 16'h020F);
    final_check(16'h000C, 16'h020F, "R8");
    check(result === 32'h000018B4, "R8 literal", result, 32'h000018B4);
    @(negedge clk);
    check(done === 1'b0, "R4 single cycle", {31'b0, done}, 32'h0);

    // R9: all ones
    run_op(16'hFFFF, 16'hFFFF);
    final_check(16'hFFFF, 16'hFFFF, "R9");
    check(result === 32'hFFFE0001, "R9 literal", result, 32'hFFFE0001);

    // back-to-back start in the done cycle
    run_op(16'h00FF, 16'hFF00);
    final_check(16'h00FF, 16'hFF00, "R1 R2");
    run_op(16'h0000, 16'hBEEF);
    final_check(16'h0000, 16'hBEEF, "R2 zero");
    run_op(16'h1234, 16'h5678);
    final_check(16'h1234, 16'h5678, "R2");
    run_op(16'hFF01, 16'h01FF);
    final_check(16'hFF01, 16'h01FF, "R3 carry");

    // R5: start and new operands while busy are ignored
    repeat (2) @(negedge clk);
    op_a  = 16'hA5A5;
    op_b  = 16'h5A5A;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op_a  = 16'hFFFF;
    op_b  = 16'h0001;
    start = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    final_check(16'hA5A5, 16'h5A5A, "R5");

    // R6: idle with changing operands and no start
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      op_a = 16'(n * 16'h1111);
      op_b = 16'(16'hFFFF - n);
    end
    check(result === 32'(16'hA5A5) * 32'(16'h5A5A), "R6 held", result, 32'(16'hA5A5) * 32'(16'h5A5A));

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule